// File: doc/BRIEF.md
# Bank Hold-Off One-Shot Timer

This block enforces a recovery gap on a memory bank after an access to it ends. One example of such a gap is a row precharge time. Each pattern engine has its own instance, built as one lane of the top module. A strobe from the engine's current microcode word arms the lane. The lane then loads a down-counter from a 4-bit delay field and records the number of the bank in use. While the count is non-zero, the lane reports a request from its engine to that recorded bank as blocked. Requests to any other bank go through at once.

Each lane is controlled by a small state machine with two named states. `HO_IDLE` means no hold-off is active. `HO_COUNT` means the counter is running down. The transitions are named as follows:
- **arm**: `HO_IDLE` to `HO_COUNT`, taken on the strobe with a non-zero delay.
- **rearm**: `HO_COUNT` to `HO_COUNT`, taken on the strobe with a non-zero delay. It reloads the full delay and the new bank.
- **cancel**: `HO_COUNT` to `HO_IDLE`, taken on the strobe with a zero delay.
- **expire**: `HO_COUNT` to `HO_IDLE`, taken when the count steps from 1 to 0.
- **tick**: `HO_COUNT` to `HO_COUNT`, taken on any other decrement.

The strobe takes priority over the decrement. The bank decoder, the pattern engines and the arbitration between banks lie outside this block.

Top module: `bank_holdoff_timer`

## Requirements
- R1: After reset, every lane's `busy` and `blocked` outputs are 0.
- R2: When `arm[e]` is sampled high with a delay D between 1 and 15, `busy[e]` is high for exactly D clock cycles after that edge. It drops in the cycle in which the count reaches zero.
- R3: When `arm[e]` is sampled high with a delay of 0, `busy[e]` is low in the following cycle. No hold-off is applied.
- R4: `blocked[e]` is high only when `req_valid[e]` is high, `busy[e]` is high, and `req_bank[e]` equals the bank captured on the most recent arm. It is high whenever all three conditions hold.
- R5: While lane e is busy, a request from lane e to any bank other than the captured one has `blocked[e]` low.
- R6: A strobe that arrives while the lane is busy reloads the full new delay. It also captures the new bank, so the old bank becomes free in the next cycle.
- R7: Lanes are independent. Arming or requesting on one lane does not change `busy` or `blocked` on another lane.
- R8: The delay field is used only on the edge where the strobe is sampled. Changing it while the lane counts has no effect on the remaining hold-off.
- R9: `arm_bank`, `req_bank` and `delay` are packed with lane e in bits [e*W +: W]. W is BANK_W for the bank fields and DLY_W for the delay field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | N_ENG | Per-lane trigger strobe from the microcode word |
| arm_bank | input | N_ENG*BANK_W | Bank in use when the lane is armed |
| delay | input | N_ENG*DLY_W | Per-lane programmed hold-off length |
| req_valid | input | N_ENG | Per-lane new-access request |
| req_bank | input | N_ENG*BANK_W | Target bank of the new access |
| busy | output | N_ENG | Lane hold-off timer running |
| blocked | output | N_ENG | Lane's current request must wait |

## Verification
The bench uses the default parameters: two lanes, 3-bit bank numbers and a 4-bit delay. With these values it can reach the full delay range, including 0, 1 and the maximum of 15. It can also use all eight bank numbers, so both the matching-bank and other-bank cases are covered. Having two lanes lets the bench check that arming one lane leaves the other untouched. The bench also exercises a rearm partway through a count, and a delay field that changes while the counter runs.

// File: rtl/bank_holdoff_pkg.sv
package bank_holdoff_pkg;
    typedef enum logic {
        HO_IDLE  = 1'b0,
        HO_COUNT = 1'b1
    } ho_state_e;
endpackage

// File: rtl/holdoff_downcounter.sv
module holdoff_downcounter #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             dec,
    output logic [DLY_W-1:0] count,
    output logic             at_one
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - ONE;
        end
    end

    assign at_one = (count == ONE);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && count != '0) |=> count == $past(count) - ONE);
endmodule

// File: rtl/holdoff_bank_latch.sv
module holdoff_bank_latch #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (capture) begin
            bank_q <= bank_in;
        end
    end

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bank_q));
endmodule

// File: rtl/holdoff_lane.sv
module holdoff_lane
    import bank_holdoff_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [BANK_W-1:0] arm_bank,
    input  logic [DLY_W-1:0]  delay,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    output logic              busy,
    output logic              blocked
);
    ho_state_e         state_q, state_d;
    logic [DLY_W-1:0]  count;
    logic              at_one;
    logic [BANK_W-1:0] held_bank;
    logic              delay_nz;
    logic              dec;

    assign delay_nz = (delay != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm / rearm / cancel / expire / tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HO_IDLE: begin
                if (arm && delay_nz) state_d = HO_COUNT;
            end
            HO_COUNT: begin
                if (arm) begin
                    state_d = delay_nz ? HO_COUNT : HO_IDLE;
                end else if (at_one) begin
                    state_d = HO_IDLE;
                end else begin
                    state_d = HO_COUNT;
                end
            end
            default: state_d = HO_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        blocked = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            HO_IDLE: begin
                busy = 1'b0;
            end
            HO_COUNT: begin
                busy    = 1'b1;
                dec     = !arm;
                blocked = req_valid && (req_bank == held_bank);
            end
            default: busy = 1'b0;
        endcase
    end

    holdoff_downcounter #(.DLY_W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .load_val (delay),
        .dec      (dec),
        .count    (count),
        .at_one   (at_one)
    );

    holdoff_bank_latch #(.BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (arm),
        .bank_in (arm_bank),
        .bank_q  (held_bank)
    );

    // R2
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> count != '0);

    // R2
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && delay_nz) |=> (busy && count == $past(delay)));

    // R3
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !delay_nz) |=> !busy);

    // R4
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !blocked);

    // R2
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && at_one && !arm) |=> !busy);
endmodule

// File: rtl/bank_holdoff_timer.sv
module bank_holdoff_timer #(
    parameter int N_ENG  = 2,
    parameter int BANK_W = 3,
    parameter int DLY_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_ENG-1:0]         arm,
    input  logic [N_ENG*BANK_W-1:0]  arm_bank,
    input  logic [N_ENG*DLY_W-1:0]   delay,
    input  logic [N_ENG-1:0]         req_valid,
    input  logic [N_ENG*BANK_W-1:0]  req_bank,
    output logic [N_ENG-1:0]         busy,
    output logic [N_ENG-1:0]         blocked
);
    for (genvar e = 0; e < N_ENG; e++) begin : g_lane
        holdoff_lane #(
            .BANK_W (BANK_W),
            .DLY_W  (DLY_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm       (arm[e]),
            .arm_bank  (arm_bank[e*BANK_W +: BANK_W]),
            .delay     (delay[e*DLY_W +: DLY_W]),
            .req_valid (req_valid[e]),
            .req_bank  (req_bank[e*BANK_W +: BANK_W]),
            .busy      (busy[e]),
            .blocked   (blocked[e])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (busy == '0 || rst_n));
endmodule

// File: tb/bank_holdoff_timer_tb.sv
module bank_holdoff_timer_tb;
    localparam int N_ENG  = 2;
    localparam int BANK_W = 3;
    localparam int DLY_W  = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [N_ENG-1:0]        arm = '0;
    logic [N_ENG*BANK_W-1:0] arm_bank = '0;
    logic [N_ENG*DLY_W-1:0]  delay = '0;
    logic [N_ENG-1:0]        req_valid = '0;
    logic [N_ENG*BANK_W-1:0] req_bank = '0;
    logic [N_ENG-1:0]        busy;
    logic [N_ENG-1:0]        blocked;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_holdoff_timer #(.N_ENG(N_ENG), .BANK_W(BANK_W), .DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_bank(arm_bank), .delay(delay),
        .req_valid(req_valid), .req_bank(req_bank), .busy(busy), .blocked(blocked)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lane(int e, logic [BANK_W-1:0] bk, logic [DLY_W-1:0] d);
        arm_bank[e*BANK_W +: BANK_W] = bk;
        delay[e*DLY_W +: DLY_W]      = d;
    endtask

    task automatic set_req(int e, logic v, logic [BANK_W-1:0] bk);
        req_valid[e]                 = v;
        req_bank[e*BANK_W +: BANK_W] = bk;
    endtask

    // strobe lane e for one cycle; returns at the negedge after the load edge
    task automatic fire(int e, logic [BANK_W-1:0] bk, logic [DLY_W-1:0] d);
        @(negedge clk);
        set_lane(e, bk, d);
        arm[e] = 1'b1;
        @(negedge clk);
        arm[e] = 1'b0;
    endtask

    function automatic int busy_run_len_dummy();
        return 0;
    endfunction

    task automatic measure(int e, output int n);
        n = 0;
        while (busy[e] && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 blocked", int'(blocked), 0);
    endtask

    task automatic t_length(int d);
        int n;
        fire(0, 3'd2, DLY_W'(d));
        measure(0, n);
        check($sformatf("R2 busy length d=%0d", d), n, d);
    endtask

    task automatic t_zero();
        fire(0, 3'd1, '0);
        check("R3 zero delay busy", int'(busy[0]), 0);
        set_req(0, 1'b1, 3'd1);
        #0;
        check("R3 zero delay blocked", int'(blocked[0]), 0);
        set_req(0, 1'b0, 3'd0);
    endtask

    task automatic t_match();
        int n;
        fire(0, 3'd5, 4'd6);
        set_req(0, 1'b1, 3'd5);
        #1;
        check("R4 same bank blocked", int'(blocked[0]), 1);
        set_req(0, 1'b0, 3'd5);
        #1;
        check("R4 no request not blocked", int'(blocked[0]), 0);
        set_req(0, 1'b1, 3'd4);
        #1;
        check("R5 other bank passes", int'(blocked[0]), 0);
        set_req(0, 1'b1, 3'd7);
        #1;
        check("R5 other bank 7 passes", int'(blocked[0]), 0);
        set_req(0, 1'b1, 3'd5);
        measure(0, n);
        check("R4 blocked clears at expiry", int'(blocked[0]), 0);
        set_req(0, 1'b0, 3'd0);
    endtask

    task automatic t_rearm();
        int n;
        fire(0, 3'd1, 4'd5);
        @(negedge clk);
        @(negedge clk);
        fire(0, 3'd6, 4'd7);
        set_req(0, 1'b1, 3'd1);
        #1;
        check("R6 old bank freed", int'(blocked[0]), 0);
        set_req(0, 1'b1, 3'd6);
        #1;
        check("R6 new bank blocked", int'(blocked[0]), 1);
        measure(0, n);
        check("R6 reload full delay", n, 7);
        set_req(0, 1'b0, 3'd0);
    endtask

    task automatic t_indep();
        fire(1, 3'd3, 4'd4);
        set_req(0, 1'b1, 3'd3);
        #1;
        check("R7 lane0 idle while lane1 busy", int'(busy[0]), 0);
        check("R7 lane0 not blocked", int'(blocked[0]), 0);
        check("R7 lane1 busy", int'(busy[1]), 1);
        set_req(1, 1'b1, 3'd3);
        #1;
        check("R9 lane1 field blocks", int'(blocked[1]), 1);
        repeat (6) @(negedge clk);
        set_req(0, 1'b0, 3'd0);
        set_req(1, 1'b0, 3'd0);
        check("R7 lane1 expired", int'(busy[1]), 0);
    endtask

    task automatic t_delay_change();
        int n;
        fire(0, 3'd0, 4'd3);
        set_lane(0, 3'd0, 4'd15);
        measure(0, n);
        check("R8 delay change ignored", n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_length(1);
        t_length(4);
        t_length(15);
        t_zero();
        t_match();
        t_rearm();
        t_indep();
        t_delay_change();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule